// File: doc/BRIEF.md
# Run-Ahead Branch Predictor with Prediction Queue

This block predicts branches ahead of instruction fetch without waiting for decode. A search pointer walks the code address space by itself. Each cycle it looks up one address in a tagged, direct-mapped table. A hit yields a prediction: the branch address, a direction, a target and a branch kind. The prediction is pushed into a small FIFO, and the fetch unit drains that FIFO at its own pace.

After a hit predicted taken, the pointer jumps to the stored target. Otherwise it advances by one code block. When the FIFO is full, the pointer waits and no predictions are lost. A redirect from the back end empties the FIFO and restarts the search from a new address.

Branch resolution trains the table through an update port. A miss allocates the entry. A hit moves the 2-bit saturating counter of that entry. Calls and returns live in the table like any other branch and are told apart only by their kind field.

Top module: `bp_runahead`

## Requirements
- R1: While reset is held, and after it is released, the prediction queue is empty, every table entry is invalid and the search pointer equals the RESET_PC parameter (default 0).
- R2: The table has 64 entries, is direct-mapped and indexed by address bits [7:2]. The tag is bits [31:8]. A lookup hits only when the indexed entry is valid and its tag matches.
- R3: A hit pushes one record holding the searched address, taken = counter >= 2, the stored target and the stored 2-bit kind. Records leave the queue in the order they were found.
- R4: After a miss, or after a hit predicted not taken, the search pointer advances by 16 bytes on the next cycle.
- R5: After a hit predicted taken, the search pointer loads the stored target on the next cycle.
- R6: An update that misses allocates the entry, replacing any entry with a different tag at that index. The counter becomes 2 for taken and 1 for not taken.
- R7: An update that hits increments the counter on taken and decrements it on not taken. The counter saturates at 3 and at 0. Every update also rewrites the target and the kind.
- R8: The queue holds 8 records. While it is full, the search pointer holds its value and makes no prediction. Once space frees up, the search resumes at the held block, so no block is skipped.
- R9: A redirect empties the queue and loads the search pointer with the redirect address on the same clock edge. No record is pushed in that cycle.
- R10: The head record is shown combinationally whenever q_valid is 1. Raising q_rd while q_valid is 1 removes the head at the clock edge.
- R11: Kind codes are 0 conditional, 1 jump, 2 call and 3 return. Calls and returns are stored, predicted and reported exactly like other branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Restart the search and flush the queue |
| redir_addr | input | 32 | New search address |
| upd_valid | input | 1 | Resolved branch training strobe |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| upd_kind | input | 2 | Branch kind code |
| q_rd | input | 1 | Pop the head record |
| q_valid | output | 1 | Queue holds at least one record |
| q_br_addr | output | 32 | Head record branch address |
| q_taken | output | 1 | Head record predicted direction |
| q_target | output | 32 | Head record target |
| q_kind | output | 2 | Head record kind code |

## Verification
The hardest situation to reach from the ports is a queue that fills while the pointer keeps finding branches, followed by the pointer resuming at exactly the block where it stopped. The stimulus trains ten not-taken branches into ten consecutive blocks. It then redirects to the first of them and leaves the queue unread until it is full. Finally it pops one record per cycle and expects all ten branch addresses in order, with none skipped. Counter saturation is reached by repeating updates past the ends of the counter range. The chosen update sequences give a different final direction than a counter that wraps would.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int BP_ADDR_W = 32;

    typedef enum logic [1:0] {
        BK_COND = 2'd0,
        BK_JUMP = 2'd1,
        BK_CALL = 2'd2,
        BK_RET  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic [BP_ADDR_W-1:0] br_addr;
        logic                 taken;
        logic [BP_ADDR_W-1:0] target;
        logic [1:0]           kind;
    } pred_t;
endpackage

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BP_ADDR_W-1:0] lk_addr,
    output logic                 lk_hit,
    output logic                 lk_taken,
    output logic [BP_ADDR_W-1:0] lk_target,
    output logic [1:0]           lk_kind,
    input  logic                 upd_valid,
    input  logic [BP_ADDR_W-1:0] upd_addr,
    input  logic                 upd_taken,
    input  logic [BP_ADDR_W-1:0] upd_target,
    input  logic [1:0]           upd_kind
);
    localparam int ENT   = 1 << IDX_W;
    localparam int TAG_W = BP_ADDR_W - IDX_W - IDX_LSB;

    typedef struct packed {
        logic [ENT-1:0]                vld;
        logic [ENT-1:0][TAG_W-1:0]     tag;
        logic [ENT-1:0][1:0]           ctr;
        logic [ENT-1:0][BP_ADDR_W-1:0] tgt;
        logic [ENT-1:0][1:0]           kind;
    } tbl_st_t;

    tbl_st_t s_d, s_q;

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic             u_hit;

    assign l_idx = lk_addr[IDX_LSB +: IDX_W];
    assign l_tag = lk_addr[BP_ADDR_W-1 -: TAG_W];
    assign u_idx = upd_addr[IDX_LSB +: IDX_W];
    assign u_tag = upd_addr[BP_ADDR_W-1 -: TAG_W];
    assign u_hit = s_q.vld[u_idx] && (s_q.tag[u_idx] == u_tag);

    // lookup side reads registered state only
    assign lk_hit    = s_q.vld[l_idx] && (s_q.tag[l_idx] == l_tag);
    assign lk_taken  = s_q.ctr[l_idx][1];
    assign lk_target = s_q.tgt[l_idx];
    assign lk_kind   = s_q.kind[l_idx];

    always_comb begin
        s_d = s_q;
        if (upd_valid) begin
            if (!u_hit) begin
                s_d.vld[u_idx] = 1'b1;
                s_d.tag[u_idx] = u_tag;
                s_d.ctr[u_idx] = upd_taken ? 2'd2 : 2'd1;
            end else if (upd_taken) begin
                if (s_q.ctr[u_idx] != 2'd3) s_d.ctr[u_idx] = s_q.ctr[u_idx] + 2'd1;
            end else begin
                if (s_q.ctr[u_idx] != 2'd0) s_d.ctr[u_idx] = s_q.ctr[u_idx] - 2'd1;
            end
            s_d.tgt[u_idx]  = upd_target;
            s_d.kind[u_idx] = upd_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: a missing update leaves a valid entry with the seeded counter
    a_r6_alloc_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !u_hit) |=> (s_q.vld[$past(u_idx)] &&
            (s_q.ctr[$past(u_idx)] == ($past(upd_taken) ? 2'd2 : 2'd1))));

    // R7: taken update on a saturated-high counter keeps it at 3
    a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && upd_taken && s_q.ctr[u_idx] == 2'd3)
            |=> (s_q.ctr[$past(u_idx)] == 2'd3));

    // R7: not-taken update on a counter at 0 keeps it at 0
    a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && u_hit && !upd_taken && s_q.ctr[u_idx] == 2'd0)
            |=> (s_q.ctr[$past(u_idx)] == 2'd0));
endmodule

// File: rtl/bp_queue.sv
module bp_queue
    import bp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  push,
    input  pred_t push_rec,
    input  logic  pop,
    output logic  full,
    output logic  head_valid,
    output pred_t head_rec
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        pred_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]  wr;
        logic [PTR_W-1:0]  rd;
        logic [CNT_W-1:0]  cnt;
    } q_st_t;

    q_st_t s_d, s_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full       = (s_q.cnt == CNT_W'(DEPTH));
    assign head_valid = (s_q.cnt != '0);
    assign head_rec   = s_q.mem[s_q.rd];
    assign do_push    = push && !full && !flush;
    assign do_pop     = pop && head_valid && !flush;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = push_rec;
                s_d.wr          = ptr_inc(s_q.wr);
            end
            if (do_pop) s_d.rd = ptr_inc(s_q.rd);
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: occupancy never goes past the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R8: a full queue with no pop and no flush stays full
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

    // R9: flush leaves the queue empty on the next cycle
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !head_valid);

    // R10: popping the last record without a push empties the queue
    a_r10_pop_last: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.cnt == CNT_W'(1)) |=> !head_valid);
endmodule

// File: rtl/bp_search.sv
module bp_search
    import bp_pkg::*;
#(
    parameter int                   BLK_BYTES = 16,
    parameter logic [BP_ADDR_W-1:0] RESET_PC  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redir_valid,
    input  logic [BP_ADDR_W-1:0] redir_addr,
    input  logic                 stall,
    input  logic                 hit,
    input  logic                 taken,
    input  logic [BP_ADDR_W-1:0] target,
    output logic [BP_ADDR_W-1:0] spc,
    output logic                 push
);
    localparam logic [BP_ADDR_W-1:0] STEP = BP_ADDR_W'(BLK_BYTES);

    typedef struct packed {
        logic [BP_ADDR_W-1:0] spc;
    } srch_st_t;

    srch_st_t s_d, s_q;

    assign spc  = s_q.spc;
    assign push = !redir_valid && !stall && hit;

    always_comb begin
        s_d = s_q;
        if (redir_valid)      s_d.spc = redir_addr;
        else if (stall)       s_d.spc = s_q.spc;
        else if (hit && taken) s_d.spc = target;
        else                  s_d.spc = s_q.spc + STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.spc <= RESET_PC;
        else        s_q     <= s_d;
    end

    // R9: redirect address is taken on the same edge
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (spc == $past(redir_addr)));

    // R8: stalled pointer holds
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && stall) |=> $stable(spc));

    // R4: sequential step on a miss or a not-taken hit
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !stall && !(hit && taken)) |=> (spc == $past(spc) + STEP));

    // R5: predicted-taken hit follows the target
    a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !stall && hit && taken) |=> (spc == $past(target)));
endmodule

// File: rtl/bp_runahead.sv
module bp_runahead
    import bp_pkg::*;
#(
    parameter int                   IDX_W     = 6,
    parameter int                   IDX_LSB   = 2,
    parameter int                   BLK_BYTES = 16,
    parameter int                   Q_DEPTH   = 8,
    parameter logic [BP_ADDR_W-1:0] RESET_PC  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redir_valid,
    input  logic [BP_ADDR_W-1:0] redir_addr,
    input  logic                 upd_valid,
    input  logic [BP_ADDR_W-1:0] upd_addr,
    input  logic                 upd_taken,
    input  logic [BP_ADDR_W-1:0] upd_target,
    input  logic [1:0]           upd_kind,
    input  logic                 q_rd,
    output logic                 q_valid,
    output logic [BP_ADDR_W-1:0] q_br_addr,
    output logic                 q_taken,
    output logic [BP_ADDR_W-1:0] q_target,
    output logic [1:0]           q_kind
);
    logic [BP_ADDR_W-1:0] spc;
    logic                 lk_hit, lk_taken;
    logic [BP_ADDR_W-1:0] lk_target;
    logic [1:0]           lk_kind;
    logic                 q_full, push;
    pred_t                rec_in, rec_head;

    bp_table #(.IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (spc),
        .lk_hit     (lk_hit),
        .lk_taken   (lk_taken),
        .lk_target  (lk_target),
        .lk_kind    (lk_kind),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_taken  (upd_taken),
        .upd_target (upd_target),
        .upd_kind   (upd_kind)
    );

    bp_search #(.BLK_BYTES(BLK_BYTES), .RESET_PC(RESET_PC)) u_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .stall       (q_full),
        .hit         (lk_hit),
        .taken       (lk_taken),
        .target      (lk_target),
        .spc         (spc),
        .push        (push)
    );

    always_comb begin
        rec_in.br_addr = spc;
        rec_in.taken   = lk_taken;
        rec_in.target  = lk_target;
        rec_in.kind    = lk_kind;
    end

    bp_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (redir_valid),
        .push       (push),
        .push_rec   (rec_in),
        .pop        (q_rd),
        .full       (q_full),
        .head_valid (q_valid),
        .head_rec   (rec_head)
    );

    assign q_br_addr = rec_head.br_addr;
    assign q_taken   = rec_head.taken;
    assign q_target  = rec_head.target;
    assign q_kind    = rec_head.kind;

    // R8: no record enters while the queue is full
    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !push);

    // R9: nothing is pushed in a redirect cycle
    a_r9_no_push_redir: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !push);
endmodule

// File: tb/tb_bp_runahead.sv
module tb_bp_runahead;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        redir_valid;
    logic [31:0] redir_addr;
    logic        upd_valid;
    logic [31:0] upd_addr;
    logic        upd_taken;
    logic [31:0] upd_target;
    logic [1:0]  upd_kind;
    logic        q_rd;
    logic        q_valid;
    logic [31:0] q_br_addr;
    logic        q_taken;
    logic [31:0] q_target;
    logic [1:0]  q_kind;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bp_runahead dut (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_kind(upd_kind),
        .q_rd(q_rd), .q_valid(q_valid), .q_br_addr(q_br_addr),
        .q_taken(q_taken), .q_target(q_target), .q_kind(q_kind)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] tgt;
        logic [1:0]  kind;
        logic        two;
        logic        t0;
        logic        t1;
        logic        exp_tk;
    } vec_t;

    // training vectors: one or two updates, then the expected direction
    localparam vec_t VECS [6] = '{
        '{32'h0000_1010, 32'h0000_2000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{32'h0000_1020, 32'h0000_2100, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h0000_1030, 32'h0000_2200, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
        '{32'h0000_1040, 32'h0000_2300, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_1050, 32'h0000_2400, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_1060, 32'h0000_2500, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic upd(input logic [31:0] a, input logic tk,
                       input logic [31:0] t, input logic [1:0] k);
        upd_valid = 1'b1; upd_addr = a; upd_taken = tk; upd_target = t; upd_kind = k;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic redirect(input logic [31:0] a);
        redir_valid = 1'b1; redir_addr = a;
        @(negedge clk);
        redir_valid = 1'b0;
    endtask

    task automatic pop1();
        q_rd = 1'b1;
        @(negedge clk);
        q_rd = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; redir_valid = 1'b0; redir_addr = '0;
        upd_valid = 1'b0; upd_addr = '0; upd_taken = 1'b0;
        upd_target = '0; upd_kind = '0; q_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 queue empty in reset", {31'd0, q_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 queue empty after reset", {31'd0, q_valid}, 32'd0);

        // vector walk: R3 R6 R7 R11
        for (int i = 0; i < 6; i++) begin
            upd(VECS[i].addr, VECS[i].t0, VECS[i].tgt, VECS[i].kind);
            if (VECS[i].two) upd(VECS[i].addr, VECS[i].t1, VECS[i].tgt, VECS[i].kind);
            redirect(VECS[i].addr);
            @(negedge clk);
            chk("R3 head valid", {31'd0, q_valid}, 32'd1);
            chk("R3 head address", q_br_addr, VECS[i].addr);
            chk("R6 R7 direction", {31'd0, q_taken}, {31'd0, VECS[i].exp_tk});
            chk("R3 target", q_target, VECS[i].tgt);
            chk("R11 kind", {30'd0, q_kind}, {30'd0, VECS[i].kind});
        end

        // R5: taken hit at 0x1010 jumps to 0x2000, where another branch waits
        upd(32'h2000, 1'b1, 32'h6000, 2'd1);
        redirect(32'h1010);
        @(negedge clk); @(negedge clk);
        pop1();
        chk("R5 second record follows target", q_br_addr, 32'h2000);
        chk("R10 pop exposes next head", {31'd0, q_valid}, 32'd1);

        // R4: not-taken hit at 0x1020 steps to 0x1030
        redirect(32'h1020);
        @(negedge clk); @(negedge clk);
        pop1();
        chk("R4 second record is next block", q_br_addr, 32'h1030);

        // R7 low saturation: 0x1040 is at 0; n,n,t,t gives 2
        upd(32'h1040, 1'b0, 32'h2300, 2'd3);
        upd(32'h1040, 1'b0, 32'h2300, 2'd3);
        upd(32'h1040, 1'b1, 32'h2300, 2'd3);
        upd(32'h1040, 1'b1, 32'h2300, 2'd3);
        redirect(32'h1040);
        @(negedge clk);
        chk("R7 saturate at 0", {31'd0, q_taken}, 32'd1);

        // R7 high saturation: 0x1030 is at 3; t,n,n gives 1
        upd(32'h1030, 1'b1, 32'h2200, 2'd2);
        upd(32'h1030, 1'b0, 32'h2200, 2'd2);
        upd(32'h1030, 1'b0, 32'h2200, 2'd2);
        redirect(32'h1030);
        @(negedge clk);
        chk("R7 saturate at 3", {31'd0, q_taken}, 32'd0);

        // R2 R6: 0x5010 shares index 4 with 0x1010 and replaces it
        upd(32'h5010, 1'b0, 32'h7000, 2'd0);
        redirect(32'h1010);
        @(negedge clk);
        chk("R2 replaced tag misses", {31'd0, q_valid}, 32'd0);
        @(negedge clk);
        chk("R4 R2 next block still hits", q_br_addr, 32'h1020);
        redirect(32'h5010);
        @(negedge clk);
        chk("R6 new tag found", q_br_addr, 32'h5010);
        chk("R6 seeded not taken", {31'd0, q_taken}, 32'd0);

        // R9: flush a non-empty queue
        @(negedge clk);
        chk("R9 queue holds records", {31'd0, q_valid}, 32'd1);
        redirect(32'h8000);
        chk("R9 flushed on redirect edge", {31'd0, q_valid}, 32'd0);
        @(negedge clk);
        chk("R9 no stale record", {31'd0, q_valid}, 32'd0);

        // R8: ten not-taken branches in consecutive blocks
        for (int i = 0; i < 10; i++) upd(32'h4000 + 32'(i * 16), 1'b0, 32'h9000, 2'd0);
        redirect(32'h4000);
        repeat (20) @(negedge clk);
        chk("R8 full queue valid", {31'd0, q_valid}, 32'd1);
        q_rd = 1'b1;
        for (int i = 0; i < 10; i++) begin
            chk("R8 R10 ordered resume", q_br_addr, 32'h4000 + 32'(i * 16));
            @(negedge clk);
        end
        q_rd = 1'b0;

        // R1: reset invalidates the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        redirect(32'h1020);
        @(negedge clk);
        chk("R1 table invalid after reset", {31'd0, q_valid}, 32'd0);
        @(negedge clk);
        chk("R1 table still empty", {31'd0, q_valid}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule